// File: doc/BRIEF.md
# Forward-Edge Landing Pad Checker

This block guards indirect control transfers of one hart. It watches the stream of retiring instructions and keeps a single state bit that says whether the next retired instruction must be a landing pad. An indirect jump or call arms the bit. The exception is a branch whose source register is one of the link registers or the label register, because that class is trusted by convention. The instruction that follows must then be a 4-byte aligned landing pad whose label is zero or equals the expected label held in the upper twenty bits of the label register. If it is, the bit is cleared.

Any violation raises a fault strobe in the same cycle as the offending retire, together with a cause code and a value code for the trap logic. Trap delivery, flushing and storage of the enable all sit outside this block. The enable for the current privilege level arrives as a plain input. When it is low, the landing pad instruction is an ordinary hint and nothing is checked or armed.

Top module: `lp_guard`

## Requirements
- R1: After reset `lp_armed` is 0 and `fault_pulse` is 0.
- R2: A valid, enabled retire of an indirect branch sets `lp_armed` to 1 from the next cycle. Two forms count as indirect branches. The first is a 32-bit JALR: bits 6:0 = 1100111 and bits 14:12 = 000. The second is a compressed register jump: bits 1:0 = 10, bits 15:12 = 1000 or 1001, bits 6:2 = 0 and bits 11:7 nonzero. In both cases `ret_rs1` must not be 1, 5 or 7.
- R3: An indirect branch whose `ret_rs1` is 1, 5 or 7 never arms the state.
- R4: While `lp_armed` is 1, an enabled valid retire with `ret_pc[1:0]` nonzero faults, even when the instruction is a landing pad.
- R5: While armed, an enabled valid retire that is not a landing pad faults. A landing pad is a non-compressed instruction with bits 6:0 = 0010111 and `ret_rd` = 0; its label is bits 31:12.
- R6: While armed, an aligned landing pad faults when its label is nonzero and differs from `lbl_reg_hi`. A zero label or an equal label passes and clears `lp_armed` the next cycle.
- R7: A fault drives `fault_pulse` high only in the cycle of the `ret_valid` retire that caused it, with `fault_cause` = 18 and `fault_tval` = 2.
- R8: With `cfi_en` low no fault is raised and `lp_armed` keeps its value.
- R9: A faulting retire leaves `lp_armed` at 1, even when that retire is itself an indirect branch.
- R10: `lp_armed` changes only on a cycle where `ret_valid` is high.
- R11: A landing pad retired while not armed raises no fault and leaves `lp_armed` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retire strobe for the fields below |
| ret_insn | input | 32 | Retiring instruction word (compressed form in bits 15:0) |
| ret_pc | input | XLEN | Address of the retiring instruction |
| ret_rs1 | input | 5 | Decoded source register index |
| ret_rd | input | 5 | Decoded destination register index |
| ret_is_rvc | input | 1 | Instruction is 16 bits wide |
| lbl_reg_hi | input | 20 | Upper twenty bits of the label register |
| cfi_en | input | 1 | Forward-edge enable for the current privilege level |
| fault_pulse | output | 1 | Landing pad fault, one cycle with the retire |
| fault_cause | output | 6 | Exception cause, valid with the pulse |
| fault_tval | output | 4 | Fault value code, valid with the pulse |
| lp_armed | output | 1 | Current expected-landing-pad state |

## Verification
The fault and its codes are combinational from the retire fields, so they are due in the retire cycle itself. The bench samples them a quarter period after it drives the inputs on the falling edge, before the next rising edge. The state bit passes through one register, so its new value is due one edge after the retire. The bench reads it a short time after that rising edge, with the strobe still applied, so that each check sees exactly one update.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int INSN_W   = 32;
  localparam int REG_W    = 5;
  localparam int LBL_W    = 20;
  localparam int CAUSE_W  = 6;
  localparam int TVAL_W   = 4;

  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [1:0] RVC_Q2    = 2'b10;

  localparam logic [REG_W-1:0] RA_MAIN = 5'd1;
  localparam logic [REG_W-1:0] RA_ALT  = 5'd5;
  localparam logic [REG_W-1:0] RA_LBL  = 5'd7;

  typedef enum logic {ST_IDLE = 1'b0, ST_EXPECT = 1'b1} lp_state_e;

  typedef struct packed {
    logic ind_branch;
    logic trusted_src;
    logic lpad;
    logic [LBL_W-1:0] label;
  } lp_dec_t;

  function automatic logic f_jalr32(input logic [INSN_W-1:0] w);
    return (w[6:0] == OPC_JALR) && (w[14:12] == 3'b000);
  endfunction

  function automatic logic f_cjump(input logic [15:0] h);
    return (h[1:0] == RVC_Q2) && (h[15:13] == 3'b100) &&
           (h[6:2] == 5'd0) && (h[11:7] != 5'd0);
  endfunction

  function automatic logic f_trusted(input logic [REG_W-1:0] r);
    return (r == RA_MAIN) || (r == RA_ALT) || (r == RA_LBL);
  endfunction

  function automatic logic f_label_ok(input logic [LBL_W-1:0] got,
                                      input logic [LBL_W-1:0] want);
    return (got == '0) || (got == want);
  endfunction
endpackage

// File: rtl/lpg_decode.sv
module lpg_decode
  import lpg_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              is_rvc,
  input  logic [REG_W-1:0]  rs1,
  input  logic [REG_W-1:0]  rd,
  output lp_dec_t           dec
);
  logic br32, br16;

  always_comb begin
    br32 = !is_rvc && f_jalr32(insn);
    br16 = is_rvc && f_cjump(insn[15:0]);
    dec.ind_branch  = br32 || br16;
    dec.trusted_src = f_trusted(rs1);
    dec.lpad        = !is_rvc && (insn[6:0] == OPC_AUIPC) && (rd == '0);
    dec.label       = insn[INSN_W-1 -: LBL_W];
  end
endmodule

// File: rtl/lpg_judge.sv
module lpg_judge
  import lpg_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ALIGN_B = 2
) (
  input  logic              valid,
  input  logic              en,
  input  logic              armed,
  input  logic [XLEN-1:0]   pc,
  input  logic [LBL_W-1:0]  want_lbl,
  input  lp_dec_t           dec,
  output logic              misalign,
  output logic              bad_label,
  output logic              fault,
  output logic              arm_req,
  output logic              clr_req
);
  logic active;

  always_comb begin
    active    = valid && en;
    misalign  = |pc[ALIGN_B-1:0];
    bad_label = dec.lpad && !f_label_ok(dec.label, want_lbl);
    fault     = active && armed && (misalign || !dec.lpad || bad_label);
    arm_req   = active && !fault && dec.ind_branch && !dec.trusted_src;
    clr_req   = active && armed && !fault && dec.lpad;
  end
endmodule

// File: rtl/lpg_state.sv
module lpg_state
  import lpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic clr_req,
  output logic armed
);
  lp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (arm_req)      st_d = ST_EXPECT;
    else if (clr_req) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == ST_EXPECT);
endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lpg_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ret_valid,
  input  logic [INSN_W-1:0]   ret_insn,
  input  logic [XLEN-1:0]     ret_pc,
  input  logic [REG_W-1:0]    ret_rs1,
  input  logic [REG_W-1:0]    ret_rd,
  input  logic                ret_is_rvc,
  input  logic [LBL_W-1:0]    lbl_reg_hi,
  input  logic                cfi_en,
  output logic                fault_pulse,
  output logic [CAUSE_W-1:0]  fault_cause,
  output logic [TVAL_W-1:0]   fault_tval,
  output logic                lp_armed
);
  localparam int ALIGN_B = 2;

  lp_dec_t dec;
  logic misalign, bad_label, fault, arm_req, clr_req;
  logic br_arms, lp_seen;

  lpg_decode u_dec (
    .insn(ret_insn), .is_rvc(ret_is_rvc), .rs1(ret_rs1), .rd(ret_rd), .dec(dec)
  );

  lpg_judge #(.XLEN(XLEN), .ALIGN_B(ALIGN_B)) u_judge (
    .valid(ret_valid), .en(cfi_en), .armed(lp_armed), .pc(ret_pc),
    .want_lbl(lbl_reg_hi), .dec(dec), .misalign(misalign),
    .bad_label(bad_label), .fault(fault), .arm_req(arm_req), .clr_req(clr_req)
  );

  lpg_state u_state (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .clr_req(clr_req),
    .armed(lp_armed)
  );

  assign br_arms     = dec.ind_branch && !dec.trusted_src;
  assign lp_seen     = dec.lpad;
  assign fault_pulse = fault;
  assign fault_cause = fault ? CAUSE_W'(CAUSE_CODE) : '0;
  assign fault_tval  = fault ? TVAL_W'(TVAL_CODE) : '0;
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker
  import lpg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ret_valid,
  input logic [REG_W-1:0]   ret_rs1,
  input logic               cfi_en,
  input logic               fault_pulse,
  input logic [CAUSE_W-1:0] fault_cause,
  input logic [TVAL_W-1:0]  fault_tval,
  input logic               lp_armed,
  input logic               br_arms,
  input logic               lp_seen
);
  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && cfi_en && !fault_pulse && br_arms |=> lp_armed);

  p_guarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !lp_armed && (ret_rs1 == RA_LBL) |=> !lp_armed);

  p_fault_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> lp_armed && ret_valid && cfi_en);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && cfi_en && lp_armed && lp_seen && !fault_pulse |=> !lp_armed);

  p_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (fault_cause == CAUSE_W'(18)) && (fault_tval == TVAL_W'(2)));

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !cfi_en |=> $stable(lp_armed));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> lp_armed);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> $stable(lp_armed));
endmodule

bind lp_guard lpg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_rs1(ret_rs1),
  .cfi_en(cfi_en), .fault_pulse(fault_pulse), .fault_cause(fault_cause),
  .fault_tval(fault_tval), .lp_armed(lp_armed), .br_arms(br_arms),
  .lp_seen(lp_seen)
);

// File: tb/test_lp_guard.sv
module test_lp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic ret_valid = 0;
  logic [31:0] ret_insn = '0;
  logic [XLEN-1:0] ret_pc = '0;
  logic [4:0] ret_rs1 = '0, ret_rd = '0;
  logic ret_is_rvc = 0;
  logic [19:0] lbl_reg_hi = '0;
  logic cfi_en = 1;
  logic fault_pulse, lp_armed;
  logic [5:0] fault_cause;
  logic [3:0] fault_tval;

  int checks = 0, errors = 0;
  logic f_seen, a_seen;
  logic [5:0] c_seen;
  logic [3:0] t_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_guard #(.XLEN(XLEN)) i_lp_guard (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_insn(ret_insn),
    .ret_pc(ret_pc), .ret_rs1(ret_rs1), .ret_rd(ret_rd),
    .ret_is_rvc(ret_is_rvc), .lbl_reg_hi(lbl_reg_hi), .cfi_en(cfi_en),
    .fault_pulse(fault_pulse), .fault_cause(fault_cause),
    .fault_tval(fault_tval), .lp_armed(lp_armed)
  );

  function automatic logic [31:0] e_jalr(input logic [4:0] rs, input logic [4:0] rd);
    return {12'h0, rs, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] e_cjr(input logic [4:0] rs, input logic link);
    return {16'h0, 3'b100, link, rs, 5'd0, 2'b10};
  endfunction
  function automatic logic [31:0] e_lpad(input logic [19:0] lbl);
    return {lbl, 5'd0, 7'b0010111};
  endfunction
  localparam logic [31:0] NOP = 32'h0000_0013;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic retire(input logic [31:0] insn, input logic [XLEN-1:0] pc,
                        input logic [4:0] rs, input logic [4:0] rd,
                        input logic rvc, input logic valid);
    @(negedge clk);
    ret_insn = insn; ret_pc = pc; ret_rs1 = rs; ret_rd = rd;
    ret_is_rvc = rvc; ret_valid = valid;
    #(CLK_PERIOD/4);
    f_seen = fault_pulse; c_seen = fault_cause; t_seen = fault_tval;
    @(posedge clk); #1;
    a_seen = lp_armed;
    ret_valid = 0;
  endtask

  task automatic arm();
    retire(e_jalr(5'd10, 5'd0), 64'h1000, 5'd10, 5'd0, 0, 1);
  endtask

  task automatic disarm();
    retire(e_lpad(20'h0), 64'h2000, 5'd0, 5'd0, 0, 1);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 armed", lp_armed, 0);
    chk("R1 fault", fault_pulse, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_arm_forms();
    arm(); chk("R2 jalr arms", a_seen, 1);
    disarm(); chk("R6 zero label clears", a_seen, 0);
    retire(e_cjr(5'd12, 0), 64'h1002, 5'd12, 5'd0, 1, 1);
    chk("R2 c.jr arms", a_seen, 1);
    disarm();
    retire(e_cjr(5'd9, 1), 64'h1004, 5'd9, 5'd1, 1, 1);
    chk("R2 c.jalr arms", a_seen, 1);
    disarm();
    retire(NOP, 64'h1008, 5'd10, 5'd0, 0, 1);
    chk("R2 plain op no arm", a_seen, 0);
  endtask

  task automatic t_guarded();
    retire(e_jalr(5'd1, 5'd0), 64'h1000, 5'd1, 5'd0, 0, 1);
    chk("R3 x1 no arm", a_seen, 0);
    retire(e_jalr(5'd5, 5'd1), 64'h1000, 5'd5, 5'd1, 0, 1);
    chk("R3 x5 no arm", a_seen, 0);
    retire(e_jalr(5'd7, 5'd0), 64'h1000, 5'd7, 5'd0, 0, 1);
    chk("R3 x7 no arm", a_seen, 0);
    retire(e_cjr(5'd7, 0), 64'h1000, 5'd7, 5'd0, 1, 1);
    chk("R3 c.jr x7 no arm", a_seen, 0);
  endtask

  task automatic t_misalign();
    arm();
    retire(e_lpad(20'h0), 64'h2002, 5'd0, 5'd0, 0, 1);
    chk("R4 misaligned lpad faults", f_seen, 1);
    chk("R4 stays armed", a_seen, 1);
    disarm();
  endtask

  task automatic t_not_lp();
    arm();
    retire(NOP, 64'h2000, 5'd0, 5'd0, 0, 1);
    chk("R5 non-lpad faults", f_seen, 1);
    chk("R7 cause", c_seen, 18);
    chk("R7 tval", t_seen, 2);
    disarm();
    arm();
    retire(e_lpad(20'h0), 64'h2000, 5'd0, 5'd3, 0, 1);
    chk("R5 auipc rd!=0 faults", f_seen, 1);
    disarm();
    @(negedge clk); #1;
    chk("R7 pulse gone", fault_pulse, 0);
  endtask

  task automatic t_labels();
    lbl_reg_hi = 20'h12345;
    arm();
    retire(e_lpad(20'h12345), 64'h2000, 5'd0, 5'd0, 0, 1);
    chk("R6 equal label ok", f_seen, 0);
    chk("R6 equal label clears", a_seen, 0);
    arm();
    retire(e_lpad(20'h00F00), 64'h2000, 5'd0, 5'd0, 0, 1);
    chk("R6 mismatch faults", f_seen, 1);
    chk("R6 mismatch stays armed", a_seen, 1);
    retire(e_lpad(20'h0), 64'h2000, 5'd0, 5'd0, 0, 1);
    chk("R6 zero label ok", f_seen, 0);
    chk("R6 zero label clears", a_seen, 0);
    lbl_reg_hi = '0;
  endtask

  task automatic t_disabled();
    cfi_en = 0;
    arm(); chk("R8 no arm when off", a_seen, 0);
    cfi_en = 1; arm(); cfi_en = 0;
    retire(NOP, 64'h2002, 5'd0, 5'd0, 0, 1);
    chk("R8 no check when off", f_seen, 0);
    chk("R8 state held", a_seen, 1);
    retire(e_lpad(20'h0), 64'h2000, 5'd0, 5'd0, 0, 1);
    chk("R8 lpad no clear when off", a_seen, 1);
    cfi_en = 1; disarm();
  endtask

  task automatic t_precedence();
    arm();
    retire(e_jalr(5'd11, 5'd0), 64'h2000, 5'd11, 5'd0, 0, 1);
    chk("R9 branch while armed faults", f_seen, 1);
    chk("R9 state left at 1", a_seen, 1);
    disarm();
  endtask

  task automatic t_no_valid();
    retire(e_jalr(5'd10, 5'd0), 64'h1000, 5'd10, 5'd0, 0, 0);
    chk("R10 invalid branch no arm", a_seen, 0);
    arm();
    retire(NOP, 64'h2002, 5'd0, 5'd0, 0, 0);
    chk("R10 invalid no fault", f_seen, 0);
    chk("R10 invalid no change", a_seen, 1);
    disarm();
  endtask

  task automatic t_idle_lp();
    lbl_reg_hi = 20'h00001;
    retire(e_lpad(20'hABCDE), 64'h3002, 5'd0, 5'd0, 0, 1);
    chk("R11 idle lpad no fault", f_seen, 0);
    chk("R11 idle lpad state", a_seen, 0);
    lbl_reg_hi = '0;
  endtask

  initial begin
    t_reset();
    t_arm_forms();
    t_guarded();
    t_misalign();
    t_not_lp();
    t_labels();
    t_disabled();
    t_precedence();
    t_no_valid();
    t_idle_lp();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule